// File: doc/BRIEF.md
# Dual-Image Transactional Line Buffer

This block is a small, fully associative store of cache lines that a running transaction has touched. Every line a transaction reads or writes is held here with two copies: the value the line had when the transaction first touched it, and the speculative value the transaction is building. Lines left over from earlier transactions stay in a clean state and can be hit again by later transactions. A transaction starts implicitly with its first access. It ends with an explicit commit or abort command. A status output lets software ask whether the transaction is already doomed.

While a transaction runs, the buffer watches snoop requests from other agents. A snoop that would break the transaction's isolation is refused with a negative acknowledgement, and the buffer then aborts its own transaction at once. Commit and abort never move data. Each entry only changes state and flips a selector that names which of its two copies is now the line's value. Register rollback is left to software. The main data cache and the full coherence protocol sit outside this block; the caller supplies the line's memory value with each access as fill data.

Top module: `dual_image_txbuf`

## Requirements
- R1: After reset every entry is free, `tx_doomed` is 0 and all response outputs are 0.
- R2: A transactional load that misses allocates an entry whose two copies both take `req_fill`, and it returns `req_fill`. A load that hits returns the buffered value and ignores `req_fill`.
- R3: A transactional store writes only the speculative copy and returns the written data, and later loads in the same transaction return it. A line that is only read is still held as a transactional entry.
- R4: A commit with no abort pending answers `cmd_ok`=1 and makes the speculative copy the value of every transactional line, which later loads return.
- R5: An abort command answers `cmd_ok`=1 and makes the pre-transaction copy the value of every transactional line, which later loads return.
- R6: A snoop conflicts when its address matches a transactional line that is either written (any snoop) or only read with an exclusive snoop (`snp_excl`=1). Only a conflicting snoop raises `snp_nack`. A shared snoop to a line that is only read does not.
- R7: A conflicting snoop discards the transaction as an abort would and sets `tx_doomed`. While doomed, accesses answer `acc_ok`=0 with `acc_rdata`=0 and change nothing. A commit while doomed answers `cmd_ok`=0, and any command clears `tx_doomed`.
- R8: An exclusive snoop to a clean (non-transactional) line frees that line without a negative acknowledgement, so the next load of it misses and returns `req_fill`.
- R9: A miss allocates the lowest free entry, else the lowest clean entry. If every entry is transactional, the access answers `acc_ok`=0, the transaction is aborted and `tx_doomed` is set.
- R10: An access presented in the same cycle as a snoop or a command answers `acc_ok`=0 and leaves every line unchanged.
- R11: Every response appears exactly one cycle after its request and lasts one cycle. `acc_done` follows `req_valid`, `snp_nack` follows the snoop, and `cmd_done` follows `cmd_commit` or `cmd_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transactional access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Line address of the access |
| req_wdata | input | DW | Store data |
| req_fill | input | DW | Current memory value of the line, used on a miss |
| snp_valid | input | 1 | Snoop request from another agent |
| snp_excl | input | 1 | 1 = snoop wants write or exclusive ownership |
| snp_addr | input | AW | Snoop line address |
| cmd_commit | input | 1 | Commit the running transaction |
| cmd_abort | input | 1 | Abort the running transaction (wins over commit) |
| acc_done | output | 1 | Access response valid |
| acc_ok | output | 1 | Access performed |
| acc_rdata | output | DW | Load value or stored value, 0 when refused |
| snp_nack | output | 1 | Snoop refused |
| cmd_done | output | 1 | Command response valid |
| cmd_ok | output | 1 | Command succeeded |
| tx_doomed | output | 1 | Validate status: an abort is pending |

## Verification
Each response is registered, so an access, snoop or command placed on the inputs at one falling edge is answered at the next falling edge, one rising edge later. `tx_doomed` changes at that same edge. The bench drives every stimulus on a falling edge, waits exactly one falling edge, and then checks the response together with the flags that must stay low for the other request types. Values that a commit, abort, invalidation or eviction left behind are checked through later loads, and each of those loads is itself checked one cycle later.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  // Entry states: free, clean (holds a committed value), and two transactional states
  typedef enum logic [1:0] {
    LN_FREE  = 2'd0,
    LN_CLEAN = 2'd1,
    LN_TX_RD = 2'd2,
    LN_TX_WR = 2'd3
  } line_st_t;

  function automatic logic is_tx(line_st_t s);
    return (s == LN_TX_RD) || (s == LN_TX_WR);
  endfunction

  // A written line is disturbed by any snoop; a read-only line only by exclusive ones
  function automatic logic snoop_conflicts(line_st_t s, logic excl);
    return (s == LN_TX_WR) || ((s == LN_TX_RD) && excl);
  endfunction

  // Index of the lowest set bit; 0 when none is set
  function automatic int first_one(logic [31:0] v);
    int idx;
    idx = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

endpackage

// File: rtl/txbuf_lookup.sv
module txbuf_lookup #(
  parameter int N  = 4,
  parameter int AW = 8
) (
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0]         live,
  input  logic [AW-1:0]        addr,
  output logic [N-1:0]         match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = live[i] && (tags[i] == addr);
  end
endmodule

// File: rtl/txbuf_alloc.sv
module txbuf_alloc
  import txbuf_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_vec,
  input  logic [N-1:0]  clean_vec,
  output logic [IW-1:0] grant_idx,
  output logic          grant_ok
);
  logic [N-1:0] pool;

  // Free entries are preferred; otherwise a clean line is sacrificed
  assign pool      = (|free_vec) ? free_vec : clean_vec;
  assign grant_ok  = |pool;
  assign grant_idx = IW'(first_one(32'(pool)));
endmodule

// File: rtl/dual_image_txbuf.sv
module dual_image_txbuf
  import txbuf_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_fill,
  input  logic          snp_valid,
  input  logic          snp_excl,
  input  logic [AW-1:0] snp_addr,
  input  logic          cmd_commit,
  input  logic          cmd_abort,
  output logic          acc_done,
  output logic          acc_ok,
  output logic [DW-1:0] acc_rdata,
  output logic          snp_nack,
  output logic          cmd_done,
  output logic          cmd_ok,
  output logic          tx_doomed
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  line_st_t                st_q [N];
  logic [N-1:0][AW-1:0]    tag_q;
  logic [DW-1:0]           old_q [N];
  logic [DW-1:0]           new_q [N];
  logic [N-1:0]            sel_new_q;
  logic                    doomed_q;

  logic [N-1:0] live_vec, free_vec, clean_vec, tx_vec;
  logic [N-1:0] hit_vec, snp_hit_vec, conflict_vec, kill_vec;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      live_vec[i]     = (st_q[i] != LN_FREE);
      free_vec[i]     = (st_q[i] == LN_FREE);
      clean_vec[i]    = (st_q[i] == LN_CLEAN);
      tx_vec[i]       = is_tx(st_q[i]);
      conflict_vec[i] = snp_hit_vec[i] && snoop_conflicts(st_q[i], snp_excl);
      kill_vec[i]     = snp_valid && snp_excl && snp_hit_vec[i] && clean_vec[i];
    end
  end

  txbuf_lookup #(.N(N), .AW(AW)) u_req_lookup (
    .tags(tag_q), .live(live_vec), .addr(req_addr), .match(hit_vec));

  txbuf_lookup #(.N(N), .AW(AW)) u_snp_lookup (
    .tags(tag_q), .live(live_vec), .addr(snp_addr), .match(snp_hit_vec));

  logic [IW-1:0] alloc_idx;
  logic          alloc_ok;

  txbuf_alloc #(.N(N)) u_alloc (
    .free_vec(free_vec), .clean_vec(clean_vec),
    .grant_idx(alloc_idx), .grant_ok(alloc_ok));

  // Named internal events
  logic          hit, tgt_is_tx, tgt_was_wr;
  logic [IW-1:0] hit_idx, tgt_idx;
  logic [DW-1:0] base_val;
  logic          ev_nack, acc_go, ev_overflow, ev_access, ev_commit, ev_discard;

  assign hit         = |hit_vec;
  assign hit_idx     = IW'(first_one(32'(hit_vec)));
  assign ev_nack     = snp_valid && (|conflict_vec);
  assign acc_go      = req_valid && !doomed_q && !snp_valid && !cmd_commit && !cmd_abort;
  assign ev_overflow = acc_go && !hit && !alloc_ok;
  assign ev_access   = acc_go && (hit || alloc_ok);
  assign tgt_idx     = hit ? hit_idx : alloc_idx;
  assign tgt_is_tx   = hit && is_tx(st_q[hit_idx]);
  assign tgt_was_wr  = hit && (st_q[hit_idx] == LN_TX_WR);
  assign ev_commit   = cmd_commit && !cmd_abort && !doomed_q && !ev_nack;
  assign ev_discard  = cmd_abort || ev_nack || ev_overflow || (cmd_commit && doomed_q);

  always_comb begin
    if (!hit)           base_val = req_fill;
    else if (tgt_is_tx) base_val = new_q[hit_idx];
    else                base_val = sel_new_q[hit_idx] ? new_q[hit_idx] : old_q[hit_idx];
  end

  // Entry storage: commit/abort only flip state and the image selector
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        st_q[i]      <= LN_FREE;
        tag_q[i]     <= '0;
        old_q[i]     <= '0;
        new_q[i]     <= '0;
        sel_new_q[i] <= 1'b0;
      end else if (ev_commit && tx_vec[i]) begin
        st_q[i]      <= LN_CLEAN;
        sel_new_q[i] <= 1'b1;
      end else if (ev_discard && tx_vec[i]) begin
        st_q[i]      <= LN_CLEAN;
        sel_new_q[i] <= 1'b0;
      end else if (kill_vec[i]) begin
        st_q[i]      <= LN_FREE;
      end else if (ev_access && (tgt_idx == IW'(i))) begin
        if (!tgt_is_tx) begin
          tag_q[i] <= req_addr;
          old_q[i] <= base_val;
        end
        new_q[i] <= req_write ? req_wdata : base_val;
        st_q[i]  <= (req_write || tgt_was_wr) ? LN_TX_WR : LN_TX_RD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doomed_q  <= 1'b0;
      acc_done  <= 1'b0;
      acc_ok    <= 1'b0;
      acc_rdata <= '0;
      snp_nack  <= 1'b0;
      cmd_done  <= 1'b0;
      cmd_ok    <= 1'b0;
    end else begin
      if (cmd_commit || cmd_abort)     doomed_q <= 1'b0;
      else if (ev_nack || ev_overflow) doomed_q <= 1'b1;
      acc_done  <= req_valid;
      acc_ok    <= ev_access;
      acc_rdata <= ev_access ? (req_write ? req_wdata : base_val) : '0;
      snp_nack  <= ev_nack;
      cmd_done  <= cmd_commit || cmd_abort;
      cmd_ok    <= cmd_abort || ev_commit;
    end
  end

  assign tx_doomed = doomed_q;

  // ---------------- assertions ----------------
  p_unique_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_commit_ends_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (tx_vec == '0) && cmd_done && cmd_ok);

  p_discard_ends_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> (tx_vec == '0));

  p_nack_dooms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && !cmd_commit && !cmd_abort) |=> snp_nack && tx_doomed);

  p_doomed_refuses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_doomed && req_valid) |=> acc_done && !acc_ok);

  p_doomed_commit_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_doomed && cmd_commit && !cmd_abort) |=> cmd_done && !cmd_ok && !tx_doomed);

  p_overflow_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> tx_doomed && acc_done && !acc_ok);

  p_collision_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (snp_valid || cmd_commit || cmd_abort)) |=> acc_done && !acc_ok);

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !acc_done);

endmodule

// File: tb/dual_image_txbuf_test.sv
module dual_image_txbuf_test;
  localparam int AW = 8;
  localparam int DW = 16;

  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_CM = 3'd2,
                         OP_AB = 3'd3, OP_SS = 3'd4, OP_SX = 3'd5;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] dat;
    logic [DW-1:0] fill;
    logic          eok;    // acc_ok, cmd_ok or snp_nack, by op
    logic [DW-1:0] edat;
    logic          edoom;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    '{OP_LD, 8'h10, 16'h0000, 16'h1111, 1'b1, 16'h1111, 1'b0}, // R2 miss fill
    '{OP_ST, 8'h10, 16'h2222, 16'h0000, 1'b1, 16'h2222, 1'b0}, // R3 store
    '{OP_LD, 8'h10, 16'h0000, 16'h9999, 1'b1, 16'h2222, 1'b0}, // R2 R3 hit ignores fill
    '{OP_LD, 8'h20, 16'h0000, 16'h3333, 1'b1, 16'h3333, 1'b0},
    '{OP_SS, 8'h20, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R6 shared on read line
    '{OP_CM, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R4
    '{OP_LD, 8'h10, 16'h0000, 16'h0000, 1'b1, 16'h2222, 1'b0}, // R4 committed value
    '{OP_ST, 8'h20, 16'h4444, 16'h0000, 1'b1, 16'h4444, 1'b0},
    '{OP_AB, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R5
    '{OP_LD, 8'h20, 16'h0000, 16'h0000, 1'b1, 16'h3333, 1'b0}, // R5 old image
    '{OP_SS, 8'h10, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R6 clean line
    '{OP_SX, 8'h20, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R3 R6 R7 excl on read line
    '{OP_LD, 8'h30, 16'h0000, 16'h0005, 1'b0, 16'h0000, 1'b1}, // R7 refused while doomed
    '{OP_CM, 8'h00, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R7 commit fails
    '{OP_LD, 8'h20, 16'h0000, 16'h0000, 1'b1, 16'h3333, 1'b0}, // R7 discard kept old
    '{OP_ST, 8'h10, 16'h6666, 16'h0000, 1'b1, 16'h6666, 1'b0},
    '{OP_SS, 8'h10, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R6 shared on written line
    '{OP_AB, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{OP_LD, 8'h10, 16'h0000, 16'h0000, 1'b1, 16'h2222, 1'b0}, // R7 store discarded
    '{OP_SX, 8'h30, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R6 no line
    '{OP_CM, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{OP_SX, 8'h20, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 clean invalidate
    '{OP_LD, 8'h20, 16'h0000, 16'h7777, 1'b1, 16'h7777, 1'b0}, // R8 misses now
    '{OP_CM, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{OP_LD, 8'h40, 16'h0000, 16'h4040, 1'b1, 16'h4040, 1'b0}, // R9 free entries
    '{OP_LD, 8'h50, 16'h0000, 16'h5050, 1'b1, 16'h5050, 1'b0},
    '{OP_LD, 8'h60, 16'h0000, 16'h6060, 1'b1, 16'h6060, 1'b0}, // R9 evicts clean 0x10
    '{OP_LD, 8'h70, 16'h0000, 16'h7070, 1'b1, 16'h7070, 1'b0}, // R9 evicts clean 0x20
    '{OP_LD, 8'h80, 16'h0000, 16'h8080, 1'b0, 16'h0000, 1'b1}, // R9 overflow
    '{OP_AB, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{OP_LD, 8'h10, 16'h0000, 16'hAAAA, 1'b1, 16'hAAAA, 1'b0}, // R9 0x10 was evicted
    '{OP_LD, 8'h50, 16'h0000, 16'h0000, 1'b1, 16'h5050, 1'b0}, // R9 clean line kept
    '{OP_CM, 8'h00, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, snp_valid = 0, snp_excl = 0;
  logic cmd_commit = 0, cmd_abort = 0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_fill = '0;
  logic acc_done, acc_ok, snp_nack, cmd_done, cmd_ok, tx_doomed;
  logic [DW-1:0] acc_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  dual_image_txbuf #(.N(4), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_fill(req_fill),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .cmd_commit(cmd_commit), .cmd_abort(cmd_abort),
    .acc_done(acc_done), .acc_ok(acc_ok), .acc_rdata(acc_rdata),
    .snp_nack(snp_nack), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
    .tx_doomed(tx_doomed));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req_valid = 0; req_write = 0; snp_valid = 0; snp_excl = 0;
    cmd_commit = 0; cmd_abort = 0;
  endtask

  // Drive one operation at a falling edge; the answer is due at the next one (R11)
  task automatic run_op(vec_t v);
    clear_inputs();
    case (v.op)
      OP_LD, OP_ST: begin
        req_valid = 1; req_write = (v.op == OP_ST);
        req_addr = v.addr; req_wdata = v.dat; req_fill = v.fill;
      end
      OP_CM: cmd_commit = 1;
      OP_AB: cmd_abort = 1;
      default: begin snp_valid = 1; snp_excl = (v.op == OP_SX); snp_addr = v.addr; end
    endcase
    @(negedge clk);
    clear_inputs();
    case (v.op)
      OP_LD, OP_ST: begin
        chk("R11 acc_done", 32'(acc_done), 32'd1);
        chk("R2/R3 acc_ok", 32'(acc_ok), 32'(v.eok));
        chk("R2/R3 acc_rdata", 32'(acc_rdata), 32'(v.edat));
      end
      OP_CM, OP_AB: begin
        chk("R11 cmd_done", 32'(cmd_done), 32'd1);
        chk("R4/R5 cmd_ok", 32'(cmd_ok), 32'(v.eok));
      end
      default: chk("R6 snp_nack", 32'(snp_nack), 32'(v.eok));
    endcase
    chk("R7 tx_doomed", 32'(tx_doomed), 32'(v.edoom));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 acc_done", 32'(acc_done), 32'd0);
    chk("R1 snp_nack", 32'(snp_nack), 32'd0);
    chk("R1 cmd_done", 32'(cmd_done), 32'd0);
    chk("R1 tx_doomed", 32'(tx_doomed), 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R1: empty buffer, a snoop to any line finds nothing
    run_op('{OP_SX, 8'h10, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0});

    for (int k = 0; k < NV; k++) run_op(TBL[k]);

    // R11: responses are single-cycle pulses
    @(negedge clk);
    chk("R11 idle acc_done", 32'(acc_done), 32'd0);
    chk("R11 idle cmd_done", 32'(cmd_done), 32'd0);
    chk("R11 idle snp_nack", 32'(snp_nack), 32'd0);

    // R10: store colliding with a snoop is refused
    req_valid = 1; req_write = 1; req_addr = 8'h50; req_wdata = 16'hBEEF;
    snp_valid = 1; snp_excl = 0; snp_addr = 8'h99;
    @(negedge clk);
    clear_inputs();
    chk("R10 snoop collision acc_done", 32'(acc_done), 32'd1);
    chk("R10 snoop collision acc_ok", 32'(acc_ok), 32'd0);
    chk("R10 snoop collision snp_nack", 32'(snp_nack), 32'd0);
    run_op('{OP_LD, 8'h50, 16'h0, 16'h0, 1'b1, 16'h5050, 1'b0}); // R10 line unchanged

    // R10: store colliding with a commit is refused, commit still succeeds
    req_valid = 1; req_write = 1; req_addr = 8'h50; req_wdata = 16'hBEEF;
    cmd_commit = 1;
    @(negedge clk);
    clear_inputs();
    chk("R10 command collision acc_ok", 32'(acc_ok), 32'd0);
    chk("R10 command collision cmd_ok", 32'(cmd_ok), 32'd1);
    run_op('{OP_LD, 8'h50, 16'h0, 16'h0, 1'b1, 16'h5050, 1'b0}); // R10 line unchanged
    run_op('{OP_AB, 8'h00, 16'h0, 16'h0, 1'b1, 16'h0, 1'b0});

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule